// File: doc/BRIEF.md
# Prioritised Fault Diagnosis Encoder

This block sits between the per-event fault detectors of a dual full-bridge winding driver and the serial status return. It keeps one set of fault flags for each bridge (short to supply, source overload, open load), qualifies the open-load result, and folds everything with the thermal inputs into one registered 2-bit error code. The error code and the operation bits go into one status byte, which the serial shift register captures at the start of a frame.

Faults fall into three dominance classes. Thermal conditions are the highest class. Source overload is the middle class. Open load and short to supply form the lowest class. The highest class that is active decides the code. Codes within that class are merged by bitwise AND across the two bridges.

Open load is judged after each polarity reversal: a flyback pulse must appear within a fixed window. While a bridge runs at hold current the judgement is skipped, and a stale open flag fades after a bounded number of such reversals. A settling filter counts chopping pulses and reversals. Until it has counted four events, every judgement reports open load.

Top module: `fault_diag_enc`

## Requirements
- R1: While reset is held, and in the first cycle after it when no input is active, `err_code_o` is 2'b11, `shut_req_o` is 0 and `status_o` is {2'b11, `cmd_i`}.
- R2: When `therm_warn_i` or `therm_shut_i` is high, `err_code_o` is 2'b00 one clock later, regardless of any other fault flag.
- R3: A latched source overload on either bridge gives `err_code_o` = 2'b10 when no thermal input is high, and it overrides open-load and short-to-supply flags.
- R4: An open-load or short-to-supply flag on either bridge gives 2'b01 when no higher class is active. Flags of one class on both bridges merge by AND, so open load on A together with short on B still gives 2'b01.
- R5: A reversal strobe on `pol_chg_i[i]` opens a window of FLY_WIN (default 16) cycles. If `flyback_i[i]` pulses in a later cycle of that window, the open flag of bridge i is cleared at the window end; otherwise it is set.
- R6: The open-load window is not started when the current field of the bridge is 2'b10 (hold current). Bridge A's field is `cmd_i[5:4]` and bridge B's field is `cmd_i[2:1]`.
- R7: Until SETTLE_N (default 4) filter events have been counted since reset, every window ends with the open flag set. A filter event is any cycle with a chopping or reversal strobe. Without chopping, the first three reversals after reset therefore report 2'b01, and the fourth reports a real result.
- R8: `frame_ok_i` clears both overload flags (a new overload in the same cycle wins). It leaves the short-to-supply flags unchanged.
- R9: A short-to-supply flag is set by `short_sup_i[i]` and is cleared only by `chop_evt_i[i]` of the same bridge or by reset.
- R10: A set open flag survives at most LOWC_MAX (default 8) consecutive skipped reversals at hold current. It is cleared on the LOWC_MAX-th of them.
- R11: One clock after `therm_shut_i` is high, `shut_req_o` is 1 and `status_o[5:0]` is 6'h3F.
- R12: Otherwise `status_o` is {`err_code_o`, the `cmd_i` of the previous cycle}. Field layout: [5:4] current of A, [3] polarity of A, [2:1] current of B, [0] polarity of B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 6 | Operation bits of the command in force |
| frame_ok_i | input | 1 | Strobe: a command frame was accepted |
| chop_evt_i | input | 2 | Strobe per bridge: normal chopping trip |
| short_sup_i | input | 2 | Strobe per bridge: short to supply detected |
| src_ovl_i | input | 2 | Strobe per bridge: source overload |
| pol_chg_i | input | 2 | Strobe per bridge: polarity reversal |
| flyback_i | input | 2 | Strobe per bridge: flyback pulse seen |
| therm_warn_i | input | 1 | Level: thermal pre-alarm |
| therm_shut_i | input | 1 | Level: thermal shutdown |
| err_code_o | output | 2 | Registered error code |
| shut_req_o | output | 1 | Registered shutdown request |
| status_o | output | 8 | Status byte {error code, operation bits} |

## Verification
The encoder is driven with single faults on each bridge, one at a time, to pin down each class code. It is then driven with combined faults: open load on A with short on B shows same-class merging, overload with open load shows that the middle class overrides, and pre-alarm over overload shows that thermal wins. Reversals are given with and without a flyback pulse, at full current and at hold current, and both before and after the filter has settled. This separates a real open load from a spurious startup report and from a skipped check. The clearing tests apply frame acceptance and chopping to both flag types. They show that each flag responds only to its own clearing event.

// File: rtl/fault_diag_enc.sv
module fault_diag_enc #(
  parameter int FLY_WIN  = 16,
  parameter int SETTLE_N = 4,
  parameter int LOWC_MAX = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] cmd_i,
  input  logic       frame_ok_i,
  input  logic [1:0] chop_evt_i,
  input  logic [1:0] short_sup_i,
  input  logic [1:0] src_ovl_i,
  input  logic [1:0] pol_chg_i,
  input  logic [1:0] flyback_i,
  input  logic       therm_warn_i,
  input  logic       therm_shut_i,
  output logic [1:0] err_code_o,
  output logic       shut_req_o,
  output logic [7:0] status_o
);
  localparam int WW = $clog2(FLY_WIN) + 1;
  localparam int SW = $clog2(SETTLE_N + 1);
  localparam int LW = $clog2(LOWC_MAX) + 1;
  localparam logic [1:0] HOLD = 2'b10;

  logic [1:0] ss_q, ovl_q, open_q;
  logic [SW-1:0] settle_q;
  logic settled;
  logic [1:0] cur [2];

  assign cur[0]  = cmd_i[5:4];
  assign cur[1]  = cmd_i[2:1];
  assign settled = (settle_q >= SW'(SETTLE_N));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) settle_q <= '0;
    else if (!settled && ((|chop_evt_i) || (|pol_chg_i))) settle_q <= settle_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ss_q  <= '0;
      ovl_q <= '0;
    end else begin
      ss_q  <= short_sup_i | (ss_q & ~chop_evt_i);
      ovl_q <= src_ovl_i | (frame_ok_i ? 2'b00 : ovl_q);
    end

  for (genvar i = 0; i < 2; i++) begin : g_open
    logic          act_q, seen_q;
    logic [WW-1:0] cnt_q;
    logic [LW-1:0] lc_q;
    wire start = pol_chg_i[i] && (cur[i] != HOLD);
    wire skip  = pol_chg_i[i] && (cur[i] == HOLD);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        act_q     <= 1'b0;
        seen_q    <= 1'b0;
        cnt_q     <= '0;
        lc_q      <= '0;
        open_q[i] <= 1'b0;
      end else if (start) begin
        act_q  <= 1'b1;
        seen_q <= 1'b0;
        cnt_q  <= WW'(FLY_WIN - 1);
        lc_q   <= '0;
      end else if (skip) begin
        act_q <= 1'b0;
        if (open_q[i]) begin
          if (lc_q == LW'(LOWC_MAX - 1)) begin
            open_q[i] <= 1'b0;
            lc_q      <= '0;
          end else lc_q <= lc_q + 1'b1;
        end
      end else if (act_q) begin
        if (flyback_i[i]) seen_q <= 1'b1;
        if (cnt_q == '0) begin
          act_q     <= 1'b0;
          open_q[i] <= !(seen_q || flyback_i[i]) || !settled;
        end else cnt_q <= cnt_q - 1'b1;
      end
  end

  logic [1:0] code_b [2];
  logic [1:0] cls_b  [2];
  logic [1:0] top_cls, merged, err_d;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      if (ovl_q[i])                    begin code_b[i] = 2'b10; cls_b[i] = 2'd2; end
      else if (open_q[i] || ss_q[i])   begin code_b[i] = 2'b01; cls_b[i] = 2'd1; end
      else                             begin code_b[i] = 2'b11; cls_b[i] = 2'd0; end
    end
    top_cls = (cls_b[0] > cls_b[1]) ? cls_b[0] : cls_b[1];
    merged  = 2'b11;
    for (int i = 0; i < 2; i++)
      if (cls_b[i] == top_cls) merged = merged & code_b[i];
    err_d = (therm_warn_i || therm_shut_i) ? 2'b00 : merged;
  end

  logic [5:0] ops_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      err_code_o <= 2'b11;
      shut_req_o <= 1'b0;
      ops_q      <= '0;
    end else begin
      err_code_o <= err_d;
      shut_req_o <= therm_shut_i;
      ops_q      <= therm_shut_i ? 6'h3F : cmd_i;
    end

  assign status_o = {err_code_o, rst_n ? ops_q : cmd_i};
endmodule

// File: rtl/fault_diag_chk.sv
module fault_diag_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] cmd_i,
  input logic       frame_ok_i,
  input logic [1:0] chop_evt_i,
  input logic [1:0] src_ovl_i,
  input logic       therm_warn_i,
  input logic       therm_shut_i,
  input logic [1:0] ss_q,
  input logic [1:0] ovl_q,
  input logic [1:0] err_code_o,
  input logic       shut_req_o,
  input logic [7:0] status_o
);
  // R2
  thermal_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_warn_i || therm_shut_i) |=> err_code_o == 2'b00);
  // R3
  overload_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_q != 2'b00 && !therm_warn_i && !therm_shut_i) |=> err_code_o == 2'b10);
  // R8
  overload_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok_i |=> (ovl_q & ~$past(src_ovl_i)) == 2'b00);
  // R9
  short_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ss_q & ~chop_evt_i) != 2'b00) |=>
      ((ss_q & $past(ss_q & ~chop_evt_i)) == $past(ss_q & ~chop_evt_i)));
  // R11
  shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    therm_shut_i |=> shut_req_o && status_o[5:0] == 6'h3F);
  // R12
  ops_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !therm_shut_i |=> !shut_req_o && status_o[5:0] == $past(cmd_i));
endmodule

bind fault_diag_enc fault_diag_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .frame_ok_i(frame_ok_i),
  .chop_evt_i(chop_evt_i), .src_ovl_i(src_ovl_i), .therm_warn_i(therm_warn_i),
  .therm_shut_i(therm_shut_i), .ss_q(ss_q), .ovl_q(ovl_q),
  .err_code_o(err_code_o), .shut_req_o(shut_req_o), .status_o(status_o)
);

// File: tb/tb_fault_diag_enc.sv
module tb_fault_diag_enc;
  logic clk = 0, rst_n = 0;
  logic [5:0] cmd = '0;
  logic frame_ok = 0, therm_warn = 0, therm_shut = 0;
  logic [1:0] chop = '0, short_sup = '0, src_ovl = '0, pol = '0, fly = '0;
  logic [1:0] err;
  logic shut;
  logic [7:0] status;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fault_diag_enc dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .frame_ok_i(frame_ok),
    .chop_evt_i(chop), .short_sup_i(short_sup), .src_ovl_i(src_ovl),
    .pol_chg_i(pol), .flyback_i(fly), .therm_warn_i(therm_warn),
    .therm_shut_i(therm_shut), .err_code_o(err), .shut_req_o(shut),
    .status_o(status)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; cmd = '0; frame_ok = 0; therm_warn = 0; therm_shut = 0;
    chop = '0; short_sup = '0; src_ovl = '0; pol = '0; fly = '0;
    wait_n(2);
    rst_n = 1;
    wait_n(1);
  endtask

  task automatic settle();
    for (int k = 0; k < 4; k++) begin
      chop = 2'b11; wait_n(1); chop = '0; wait_n(1);
    end
    wait_n(2);
  endtask

  task automatic reverse(int b, bit with_fly, int gap);
    pol[b] = 1'b1; wait_n(1); pol = '0;
    if (with_fly) begin fly[b] = 1'b1; wait_n(1); fly = '0; end
    wait_n(gap);
  endtask

  task automatic t_reset();
    rst_n = 0; cmd = 6'b010101; wait_n(2);
    check("R1 err in reset", {6'b0, err}, 8'h03);
    check("R1 shut in reset", {7'b0, shut}, 8'h00);
    rst_n = 1; wait_n(2);
    check("R1 status after reset", status, {2'b11, 6'b010101});
  endtask

  task automatic t_open_detect();
    do_reset(); settle();
    reverse(0, 1, 20);
    check("R5 flyback seen", {6'b0, err}, 8'h03);
    reverse(0, 0, 20);
    check("R5 open load", {6'b0, err}, 8'h01);
    reverse(0, 1, 20);
    check("R5 open cleared", {6'b0, err}, 8'h03);
  endtask

  task automatic t_unsettled();
    do_reset();
    for (int k = 0; k < 3; k++) begin
      reverse(1, 1, 20);
      check("R7 spurious open", {6'b0, err}, 8'h01);
    end
    reverse(1, 1, 20);
    check("R7 settled", {6'b0, err}, 8'h03);
  endtask

  task automatic t_hold_skip();
    do_reset(); settle();
    cmd = 6'b000100;
    reverse(1, 0, 20);
    check("R6 hold skip B", {6'b0, err}, 8'h03);
    cmd = 6'b000000;
    reverse(1, 0, 20);
    check("R6 full current B", {6'b0, err}, 8'h01);
  endtask

  task automatic t_hold_decay();
    do_reset(); settle();
    reverse(0, 0, 20);
    check("R10 open set", {6'b0, err}, 8'h01);
    cmd = 6'b100000;
    for (int k = 0; k < 7; k++) reverse(0, 0, 2);
    check("R10 open after 7", {6'b0, err}, 8'h01);
    reverse(0, 0, 3);
    check("R10 open gone after 8", {6'b0, err}, 8'h03);
  endtask

  task automatic t_short();
    do_reset();
    short_sup = 2'b01; wait_n(1); short_sup = '0; wait_n(3);
    check("R4 short code", {6'b0, err}, 8'h01);
    frame_ok = 1; wait_n(1); frame_ok = 0; wait_n(3);
    check("R8 frame keeps short", {6'b0, err}, 8'h01);
    chop = 2'b10; wait_n(1); chop = '0; wait_n(3);
    check("R9 other chop keeps short", {6'b0, err}, 8'h01);
    chop = 2'b01; wait_n(1); chop = '0; wait_n(3);
    check("R9 own chop clears short", {6'b0, err}, 8'h03);
  endtask

  task automatic t_overload_merge();
    do_reset(); settle();
    reverse(0, 0, 1);
    short_sup = 2'b10; wait_n(1); short_sup = '0; wait_n(20);
    check("R4 merge open A short B", {6'b0, err}, 8'h01);
    src_ovl = 2'b01; wait_n(1); src_ovl = '0; wait_n(3);
    check("R3 overload overrides", {6'b0, err}, 8'h02);
    src_ovl = 2'b10; wait_n(1); src_ovl = '0; wait_n(3);
    check("R3 overload both", {6'b0, err}, 8'h02);
    therm_warn = 1; wait_n(2);
    check("R2 prealarm wins", {6'b0, err}, 8'h00);
    therm_warn = 0; wait_n(2);
    check("R2 prealarm removed", {6'b0, err}, 8'h02);
    frame_ok = 1; wait_n(1); frame_ok = 0; wait_n(3);
    check("R8 frame clears overload", {6'b0, err}, 8'h01);
  endtask

  task automatic t_shutdown();
    do_reset();
    cmd = 6'b011010; wait_n(2);
    check("R12 status pass", status, {2'b11, 6'b011010});
    therm_shut = 1; wait_n(2);
    check("R11 shut req", {7'b0, shut}, 8'h01);
    check("R11 status forced", status, 8'h3F);
    check("R2 shutdown code", {6'b0, err}, 8'h00);
    therm_shut = 0; wait_n(2);
    check("R12 status restored", status, {2'b11, 6'b011010});
    check("R11 shut released", {7'b0, shut}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_open_detect();
    t_unsettled();
    t_hold_skip();
    t_hold_decay();
    t_short();
    t_overload_merge();
    t_shutdown();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule